// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block walks a transfer descriptor for one DMA channel and turns it into a stream of array requests. A descriptor gives an array length in bytes, the number of arrays in a frame and the number of frames in a block. Source and destination each have their own signed stride between arrays and between frames. The block does not move data. It produces the addresses, counts down the work, raises completion and chaining pulses, and reloads the working descriptor from a linked slot when the block is finished.

Descriptors sit in a small internal parameter RAM of `NUM_SLOTS` slots of eight 32-bit words. A flat register port reads and writes any word. Slot 0 is the working descriptor of the channel, and the block updates it in place. Each pulse on `trig` starts one unit of work: one array, or one whole frame, depending on the sync-mode bit. Each array goes out as one request on a valid/ready handshake.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, `req_valid`, `cpl_pulse`, `chain_pulse` and `err_pulse` are low, and every descriptor word reads 0.
- R2: A write through the register port to word address `slot*8+w` is returned by a read of the same address in the following cycle. The word layout is: w0 options; w1 source address; w2 A count [15:0] and B count [31:16]; w3 destination address; w4 source B stride [15:0] and destination B stride [31:16]; w5 link slot [15:0] and B reload [31:16]; w6 source C stride [15:0] and destination C stride [31:16]; w7 C count [15:0].
- R3: With option bit 2 = 0 (array sync), each trigger emits exactly one request. The request carries the working source, the working destination, and the A count as its length. Afterwards, if the frame has more arrays, each address advances by its sign-extended B stride and the B count drops by one.
- R4: In array sync, the last array of a frame (B count = 1) sets each address to the start of that array plus its sign-extended C stride. The same array reloads the B count from the reload field and decrements the C count.
- R5: With option bit 2 = 1 (frame sync), one trigger emits B requests. Request k carries the frame start plus k times the B stride. Afterwards the working addresses become the frame start plus the C stride.
- R6: Option bit 0 (source) and option bit 1 (destination) set to 1 select FIFO addressing. That address then never changes, and `req_elem_bytes` is 2 raised to the width code in option bits 10:8, for codes 0 to 5.
- R7: The final array of a block ends with C count = 1 at the frame end. When its work ends, `cpl_pulse` rises if option bit 20 is set and `chain_pulse` rises if option bit 22 is set. Any other end of a trigger uses option bits 21 and 23 instead. The pulses last one cycle, appear in the cycle after the last handshake, and carry option bits 17:12 on `cpl_code`.
- R8: On final completion with option bit 3 clear, all eight words of slot 0 are copied from the slot named in the link field.
- R9: On final completion with option bit 3 set, slot 0 is not reloaded and its C count reads 0.
- R10: A link value of 0xFFFF, or any value that names no existing slot, clears slot 0 on final completion: every word becomes 0 except w5, which becomes 0x0000FFFF. A trigger while the A, B or C count of slot 0 is 0 pulses `err_pulse` one cycle later and emits no request.
- R11: A trigger that arrives while a unit of work is in progress is ignored.
- R12: While `req_valid` is high and `req_ready` is low, the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_addr | input | $clog2(NUM_SLOTS*8) | Word address, slot*8 + word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word |
| trig | input | 1 | Starts one unit of work |
| req_valid | output | 1 | Array request valid |
| req_ready | input | 1 | Array request accepted |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_len | output | 16 | Array length in bytes |
| req_src_fifo | output | 1 | Source uses constant FIFO addressing |
| req_dst_fifo | output | 1 | Destination uses constant FIFO addressing |
| req_elem_bytes | output | 6 | FIFO element size in bytes |
| cpl_pulse | output | 1 | Completion event |
| chain_pulse | output | 1 | Chaining event |
| cpl_code | output | 6 | Completion code of the event |
| err_pulse | output | 1 | Trigger hit a null descriptor |

## Verification
The bench builds the block with `NUM_SLOTS = 4`. That keeps the RAM small, yet leaves spare slots for a linked frame-sync descriptor and for a slot whose stale contents must not be copied. It also makes a link value of 7 an out-of-range link, which exercises the null-set path without using 0xFFFF. An array-sync descriptor with a negative destination stride and a B reload flows through a link into a frame-sync FIFO descriptor whose second frame is shorter. This puts every kind of frame end, both event classes and both null paths inside one run.

// File: rtl/dma3d_seq.sv
module dma3d_seq #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [$clog2(NUM_SLOTS*8)-1:0]   cfg_addr,
  input  logic [31:0]                      cfg_wdata,
  output logic [31:0]                      cfg_rdata,
  input  logic                             trig,
  output logic                             req_valid,
  input  logic                             req_ready,
  output logic [31:0]                      req_src,
  output logic [31:0]                      req_dst,
  output logic [15:0]                      req_len,
  output logic                             req_src_fifo,
  output logic                             req_dst_fifo,
  output logic [5:0]                       req_elem_bytes,
  output logic                             cpl_pulse,
  output logic                             chain_pulse,
  output logic [5:0]                       cpl_code,
  output logic                             err_pulse
);
  localparam int WORDS = NUM_SLOTS * 8;
  localparam int AW    = $clog2(WORDS);
  localparam int SW    = $clog2(NUM_SLOTS);

  logic [31:0] mem [WORDS];
  logic        busy;
  logic [31:0] cur_src, cur_dst;
  logic [15:0] left;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  wire [31:0] opt    = mem[0];
  wire [31:0] w_src  = mem[1];
  wire [15:0] acnt   = mem[2][15:0];
  wire [15:0] bcnt   = mem[2][31:16];
  wire [31:0] w_dst  = mem[3];
  wire [15:0] link   = mem[5][15:0];
  wire [15:0] brld   = mem[5][31:16];
  wire [15:0] ccnt   = mem[7][15:0];

  wire sam    = opt[0];
  wire dam    = opt[1];
  wire absync = opt[2];
  wire stat   = opt[3];
  wire [2:0] fwid = opt[10:8];

  wire [31:0] s_b = sam ? 32'd0 : sx(mem[4][15:0]);
  wire [31:0] d_b = dam ? 32'd0 : sx(mem[4][31:16]);
  wire [31:0] s_c = sam ? 32'd0 : sx(mem[6][15:0]);
  wire [31:0] d_c = dam ? 32'd0 : sx(mem[6][31:16]);

  wire null_set  = (acnt == 16'd0) || (bcnt == 16'd0) || (ccnt == 16'd0);
  wire fire      = busy && req_ready;
  wire last_arr  = (left == 16'd1);
  wire frame_end = absync ? last_arr : (bcnt == 16'd1);
  wire final_arr = frame_end && (ccnt == 16'd1);
  wire link_ok   = link < 16'(NUM_SLOTS);
  wire [SW-1:0] link_idx = link[SW-1:0];

  assign cfg_rdata      = mem[cfg_addr];
  assign req_valid      = busy;
  assign req_src        = cur_src;
  assign req_dst        = cur_dst;
  assign req_len        = acnt;
  assign req_src_fifo   = sam;
  assign req_dst_fifo   = dam;
  assign req_elem_bytes = 6'd1 << ((fwid > 3'd5) ? 3'd5 : fwid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (cfg_we) mem[cfg_addr] <= cfg_wdata;
      if (fire && last_arr) begin
        if (final_arr && !stat) begin
          for (int i = 0; i < 8; i++) begin
            if (link_ok) mem[AW'(i)] <= mem[{link_idx, 3'(i)}];
            else         mem[AW'(i)] <= (i == 5) ? 32'h0000_FFFF : 32'd0;
          end
        end else begin
          mem[1] <= frame_end ? w_src + s_c : w_src + s_b;
          mem[3] <= frame_end ? w_dst + d_c : w_dst + d_b;
          mem[2] <= {frame_end ? brld : bcnt - 16'd1, acnt};
          if (frame_end) mem[7] <= {mem[7][31:16], ccnt - 16'd1};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur_src     <= '0;
      cur_dst     <= '0;
      left        <= '0;
      cpl_pulse   <= 1'b0;
      chain_pulse <= 1'b0;
      cpl_code    <= '0;
      err_pulse   <= 1'b0;
    end else begin
      cpl_pulse   <= 1'b0;
      chain_pulse <= 1'b0;
      err_pulse   <= 1'b0;
      if (trig && !busy) begin
        if (null_set) err_pulse <= 1'b1;
        else begin
          busy    <= 1'b1;
          cur_src <= w_src;
          cur_dst <= w_dst;
          left    <= absync ? bcnt : 16'd1;
        end
      end
      if (fire) begin
        if (last_arr) begin
          busy        <= 1'b0;
          cpl_pulse   <= final_arr ? opt[20] : opt[21];
          chain_pulse <= final_arr ? opt[22] : opt[23];
          cpl_code    <= opt[17:12];
        end else begin
          left    <= left - 16'd1;
          cur_src <= cur_src + s_b;
          cur_dst <= cur_dst + d_b;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_len)); // R12
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !req_valid); // R10
  AST_EVT_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_pulse || chain_pulse) |-> $past(req_valid && req_ready)); // R7
  AST_FIFO_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    fire && sam && !last_arr |=> req_src == $past(req_src)); // R6
  AST_ERR_NOT_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_pulse && (cpl_pulse || chain_pulse))); // R10
  AST_BUSY_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trig && !req_ready |=> $stable(left)); // R11
endmodule

// File: tb/dma3d_seq_tb.sv
module dma3d_seq_tb;
  localparam int NS = 4;
  localparam int AW = $clog2(NS*8);

  logic clk = 0, rst_n = 0, cfg_we = 0, trig = 0, req_ready = 1;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid, req_src_fifo, req_dst_fifo, cpl_pulse, chain_pulse, err_pulse;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_len;
  logic [5:0]  req_elem_bytes, cpl_code;

  dma3d_seq #(.NUM_SLOTS(NS)) u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_cpl = 0, n_chain = 0, n_err = 0, cyc = 0;
  logic [5:0] last_code = '0;
  bit stall = 0, finished = 0;
  logic [101:0] expq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  always @(posedge clk) begin
    #1; cyc = cyc + 1;
    req_ready = !stall || (cyc % 3 != 0);
  end

  logic prev_wait = 0;
  logic [79:0] held;
  always @(negedge clk) begin
    if (cpl_pulse) begin n_cpl++; last_code = cpl_code; end
    if (chain_pulse) n_chain++;
    if (err_pulse) n_err++;
    if (req_valid && prev_wait)
      chk({req_src, req_dst, req_len} == held, "R12 hold", req_src, held[79:48]);
    if (req_valid && req_ready) begin
      if (expq.size() == 0) chk(0, "R11 unexpected request", req_src, 0);
      else begin
        logic [101:0] e;
        e = expq.pop_front();
        chk(req_src == e[101:70], "R3/R5 src", req_src, e[101:70]);
        chk(req_dst == e[69:38], "R3/R5 dst", req_dst, e[69:38]);
        chk(req_len == e[37:22], "R3 len", {16'd0, req_len}, {16'd0, e[37:22]});
        chk(req_elem_bytes == e[5:0], "R6 elem", {26'd0, req_elem_bytes}, {26'd0, e[5:0]});
      end
    end
    prev_wait = req_valid && !req_ready;
    held = {req_src, req_dst, req_len};
  end

  logic [31:0] m_src, m_dst, m_sbi, m_dbi, m_sci, m_dci;
  logic [15:0] m_a, m_b, m_c, m_rld;
  bit m_ab, m_sam, m_dam;
  logic [5:0] m_ew;

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(posedge clk); #1 cfg_addr = AW'(a); #1 d = cfg_rdata;
  endtask

  task automatic set_desc(input int s, input logic [31:0] opt, src, dst, input logic [15:0] a, b, c,
                          sbi, dbi, sci, dci, lnk, rld, input bit load);
    wr(s*8+0, opt); wr(s*8+1, src); wr(s*8+2, {b, a}); wr(s*8+3, dst);
    wr(s*8+4, {dbi, sbi}); wr(s*8+5, {rld, lnk}); wr(s*8+6, {dci, sci}); wr(s*8+7, {16'd0, c});
    if (load) begin
      m_src = src; m_dst = dst; m_a = a; m_b = b; m_c = c; m_rld = rld;
      m_ab = opt[2]; m_sam = opt[0]; m_dam = opt[1];
      m_sbi = opt[0] ? 0 : {{16{sbi[15]}}, sbi}; m_dbi = opt[1] ? 0 : {{16{dbi[15]}}, dbi};
      m_sci = opt[0] ? 0 : {{16{sci[15]}}, sci}; m_dci = opt[1] ? 0 : {{16{dci[15]}}, dci};
      m_ew = 6'd1 << ((opt[10:8] > 5) ? 3'd5 : opt[10:8]);
    end
  endtask

  task automatic expect_unit();
    int n;
    logic [31:0] cs, cd;
    n = m_ab ? int'(m_b) : 1; cs = m_src; cd = m_dst;
    for (int k = 0; k < n; k++) begin
      expq.push_back({cs, cd, m_a, 16'd0, m_ew});
      cs = cs + m_sbi; cd = cd + m_dbi;
    end
    if (m_ab || m_b == 1) begin
      m_src = m_src + m_sci; m_dst = m_dst + m_dci; m_b = m_rld; m_c = m_c - 1;
    end else begin
      m_src = m_src + m_sbi; m_dst = m_dst + m_dbi; m_b = m_b - 1;
    end
  endtask

  task automatic pulse_trig();
    @(posedge clk); #1 trig = 1;
    @(posedge clk); #1 trig = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && (expq.size() != 0 || req_valid); i++) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(expq.size() == 0, "R3/R5 missing request", expq.size(), 0);
  endtask

  task automatic run_unit(input bit extra_trig);
    expect_unit();
    pulse_trig();
    if (extra_trig) begin repeat (2) @(posedge clk); #1 trig = 1; @(posedge clk); #1 trig = 0; end
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c0, h0, e0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!req_valid && !cpl_pulse && !chain_pulse && !err_pulse, "R1 outputs", req_valid, 0);
    rd(0, d);  chk(d == 0, "R1 w0", d, 0);
    rd(31, d); chk(d == 0, "R1 w31", d, 0);

    e0 = n_err;
    pulse_trig(); repeat (3) @(posedge clk);
    chk(n_err == e0 + 1, "R10 null after reset", n_err, e0 + 1);

    wr(9, 32'hA5A5_1234); rd(9, d); chk(d == 32'hA5A5_1234, "R2 readback", d, 32'hA5A5_1234);

    set_desc(2, 32'h0030_9206, 32'h2000, 32'h3000, 16'd8, 16'd4, 16'd2,
             16'h0008, 16'h0004, 16'h0080, 16'h0010, 16'hFFFF, 16'd2, 0);
    set_desc(0, 32'h0070_5000, 32'h1000, 32'h8000, 16'd16, 16'd3, 16'd2,
             16'h0020, 16'hFFF0, 16'h0100, 16'h0040, 16'd2, 16'd3, 1);

    c0 = n_cpl; h0 = n_chain;
    run_unit(0);
    rd(1, d); chk(d == 32'h1020, "R3 src step", d, 32'h1020);
    rd(3, d); chk(d == 32'h7FF0, "R3 neg dst step", d, 32'h7FF0);
    rd(2, d); chk(d[31:16] == 2, "R3 bcnt dec", d[31:16], 2);
    chk(n_cpl == c0 + 1 && last_code == 5, "R7 intermediate cpl", last_code, 5);
    chk(n_chain == h0, "R7 no intermediate chain", n_chain, h0);

    run_unit(0); run_unit(0);
    rd(1, d); chk(d == 32'h1140, "R4 src frame end", d, 32'h1140);
    rd(3, d); chk(d == 32'h8020, "R4 dst frame end", d, 32'h8020);
    rd(2, d); chk(d[31:16] == 3, "R4 bcnt reload", d[31:16], 3);
    rd(7, d); chk(d == 1, "R4 ccnt dec", d, 1);

    run_unit(0); run_unit(0);
    c0 = n_cpl; h0 = n_chain;
    run_unit(0);
    chk(n_cpl == c0 + 1 && n_chain == h0 + 1, "R7 final cpl and chain", n_chain, h0 + 1);
    rd(0, d); chk(d == 32'h0030_9206, "R8 reload opt", d, 32'h0030_9206);
    rd(1, d); chk(d == 32'h2000, "R8 reload src", d, 32'h2000);

    set_desc(3, 32'h0030_9206, 32'h2000, 32'h3000, 16'd8, 16'd4, 16'd2,
             16'h0008, 16'h0004, 16'h0080, 16'h0010, 16'hFFFF, 16'd2, 1);
    stall = 1;
    c0 = n_cpl;
    run_unit(1);
    stall = 0;
    rd(1, d); chk(d == 32'h2080, "R5/R11 frame src", d, 32'h2080);
    rd(3, d); chk(d == 32'h3000, "R6 fifo dst fixed", d, 32'h3000);
    rd(2, d); chk(d[31:16] == 2, "R5 bcnt reload", d[31:16], 2);
    chk(n_cpl == c0 + 1 && last_code == 9, "R7 code 9", last_code, 9);

    run_unit(0);
    rd(5, d); chk(d == 32'h0000_FFFF, "R10 null link word", d, 32'h0000_FFFF);
    rd(1, d); chk(d == 0, "R10 null src", d, 0);
    e0 = n_err;
    pulse_trig(); repeat (3) @(posedge clk);
    chk(n_err == e0 + 1, "R10 err on null", n_err, e0 + 1);

    set_desc(1, 32'hDEAD_0001, 32'h1111, 32'h2222, 16'd1, 16'd1, 16'd1, 0, 0, 0, 0, 0, 0, 0);
    set_desc(0, 32'h0010_0008, 32'h5000, 32'h6000, 16'd4, 16'd1, 16'd1,
             16'h0010, 16'h0010, 16'h0020, 16'h0020, 16'd1, 16'd1, 1);
    run_unit(0);
    rd(0, d); chk(d == 32'h0010_0008, "R9 no reload", d, 32'h0010_0008);
    rd(7, d); chk(d == 0, "R9 ccnt zero", d, 0);
    e0 = n_err;
    pulse_trig(); repeat (3) @(posedge clk);
    chk(n_err == e0 + 1, "R9 err after static", n_err, e0 + 1);

    set_desc(0, 32'h0010_0000, 32'h7000, 32'h7100, 16'd4, 16'd1, 16'd1,
             0, 0, 0, 0, 16'd7, 16'd1, 1);
    run_unit(0);
    rd(5, d); chk(d == 32'h0000_FFFF, "R10 out-of-range link", d, 32'h0000_FFFF);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule